// File: doc/BRIEF.md
# Pin-Strapped Serial Register Slave

This block is a slave on a two-wire serial bus. It sits in front of a small register file that feeds core logic. It watches the clock line and the data line for start and stop conditions, and it takes part in a transfer only when the first byte carries a fixed device-type nibble followed by three address bits. Those three bits must equal the levels on three strap pins, so eight copies can share one bus.

In a write, the master sends a register pointer and then one or more data bytes. In a read, the slave returns bytes from the current pointer onward, and the pointer advances after each byte. Two 8-bit control registers are driven to the core. A read-only status byte, supplied by the core, can be read back at a separate, higher pointer.

Both bus lines are sampled and synchronised to the system clock. The open-drain data driver is modelled as a single pull-low enable.

Top module: `pinstrap_serial_regs`

## Requirements
- R1: Before a start condition (data falling while clock is high), the slave ignores all bus activity. A start seen at any time, including during a transfer, begins a new address byte and releases the data line.
- R2: The first byte after a start is acknowledged (data held low through the ninth clock) only when bits 7:4 equal 0101 and bits 3:1 equal the strap pins. Bit 0 selects the direction: 1 means read, 0 means write.
- R3: An address byte that does not match gets no acknowledge. The slave then stays off the bus until the next start.
- R4: In a write, the second byte loads the pointer and the third byte is stored in the selected register. Pointer 00h selects control register A and 01h selects control register B. Every accepted byte is acknowledged.
- R5: A data byte written to pointer 0Fh or to any pointer without a register is acknowledged but changes no register.
- R6: A read returns the byte at the current pointer: control A at 00h, control B at 01h, the status input at 0Fh, and 00h at every other pointer.
- R7: The pointer advances by one after each byte returned in a read and after each data byte written, so consecutive bytes reach consecutive registers.
- R8: When the master answers a read byte with no acknowledge (data high in the ninth clock), the slave releases the data line and drives nothing more until the next start.
- R9: A stop condition (data rising while clock is high) returns the slave to idle at any point. A data byte that was cut off by the stop is not stored.
- R10: The slave changes its data-line enable only while the clock line is low.
- R11: During reset, both control registers clear to 00h and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples both bus lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe | output | 1 | Pull-low enable for the data line |
| strap_addr | input | 3 | Hardware-strapped slave address bits |
| status_i | input | 8 | Status byte from the core, readable at 0Fh |
| ctrl_a | output | 8 | Control register A (pointer 00h) |
| ctrl_b | output | 8 | Control register B (pointer 01h) |

## Verification
The bench uses the default parameters: two synchroniser stages, device type 0101, control slots at 00h and 01h, and the status byte at 0Fh. Because the strap pins are inputs, the bench can sweep all eight strap values against all eight address codes. That covers the full 64-case match table, plus a foreign device type. Control values are swept arithmetically. Read bursts that start at 0Eh cross an unmapped slot, the status slot and the slot past it. The remaining scenarios are stop in mid-byte, traffic before any start, and a master NACK.

// File: rtl/pssr_pkg.sv
// Shared types for the pin-strapped serial register slave.
package pssr_pkg;
    // Protocol engine phase
    typedef enum logic [2:0] {
        ST_IDLE,   // off the bus, waiting for a start
        ST_RX,     // shifting in a byte from the master
        ST_ACK,    // holding the acknowledge low in the ninth clock
        ST_TX,     // shifting a byte out to the master
        ST_MACK    // waiting for the master's acknowledge
    } eng_state_t;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        RX_ADDR,
        RX_PTR,
        RX_DATA
    } rx_kind_t;
endpackage

// File: rtl/pssr_line_monitor.sv
// Line monitor: synchronises the clock and data lines to clk and flags
// clock edges plus start and stop conditions.
// Assumes the bus runs many times slower than clk (several clk cycles per
// bus half-period). Needs SYNC_STAGES >= 2.
module pssr_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_prev;
    logic         sda_prev;
    logic         scl_now;

    // Synchronisers and one-cycle history; an idle bus reads high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_prev <= scl_pipe[TOP];
            sda_prev <= sda_pipe[TOP];
        end
    end

    assign scl_now   = scl_pipe[TOP];
    assign sda_s     = sda_pipe[TOP];
    assign scl_rise  = scl_now & ~scl_prev;
    assign scl_fall  = ~scl_now & scl_prev;
    assign start_evt = scl_now & scl_prev & sda_prev & ~sda_s;
    assign stop_evt  = scl_now & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/pssr_engine.sv
// Protocol engine: frames bytes, decodes the address byte, acknowledges,
// keeps the register pointer and serialises read data.
// Assumes the event inputs come from pssr_line_monitor. Every change to
// sda_oe happens on a clock-fall event, except the release on start/stop.
module pssr_engine
    import pssr_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [2:0] strap_addr,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_ptr,
    output logic       wr_en,
    output logic [7:0] wr_ptr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    localparam logic [3:0] FULL = 4'd8;

    eng_state_t state;
    rx_kind_t   kind;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic [7:0] ptr;
    logic       go_tx;
    logic       mack_ok;
    logic       addr_match;

    assign addr_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_addr);
    assign rd_ptr     = ptr;

    // Bus protocol state machine; stop and start override every phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= RX_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            ptr     <= '0;
            go_tx   <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_ptr  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_evt) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_evt) begin
                state  <= ST_RX;
                kind   <= RX_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_RX: begin
                        if (scl_rise && bitcnt < FULL) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == FULL) begin
                            unique case (kind)
                                RX_ADDR: begin
                                    if (addr_match) begin
                                        sda_oe <= 1'b1;
                                        go_tx  <= shreg[0];
                                        state  <= ST_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                RX_PTR: begin
                                    ptr    <= shreg;
                                    go_tx  <= 1'b0;
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_ptr  <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 8'd1;
                                    go_tx   <= 1'b0;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (go_tx) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 8'd1;
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                kind   <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == FULL) begin
                                sda_oe  <= 1'b0;
                                mack_ok <= 1'b0;
                                state   <= ST_MACK;
                            end else begin
                                sda_oe <= ~tx[6];
                                tx     <= {tx[6:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (!sda_s) mack_ok <= 1'b1;
                            else        state   <= ST_IDLE;
                        end else if (scl_fall && mack_ok) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr    <= ptr + 8'd1;
                            bitcnt <= '0;
                            state  <= ST_TX;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pssr_regfile.sv
// Register file: CTRL_COUNT writable control slots at consecutive pointers
// from CTRL_BASE, plus a read-only status slot. Unmapped pointers read 00h.
// Assumes STATUS_PTR lies outside the control slot range.
module pssr_regfile #(
    parameter int         CTRL_COUNT = 2,
    parameter int         CTRL_BASE  = 0,
    parameter logic [7:0] STATUS_PTR = 8'h0F
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_ptr,
    input  logic [7:0]              wr_data,
    input  logic [7:0]              rd_ptr,
    input  logic [7:0]              status_i,
    output logic [7:0]              rd_data,
    output logic [CTRL_COUNT*8-1:0] ctrl_q
);
    logic [7:0] slot_q [CTRL_COUNT];

    for (genvar i = 0; i < CTRL_COUNT; i++) begin : g_slot
        localparam logic [7:0] SLOT_PTR = 8'(CTRL_BASE + i);
        // Holds one control byte; loads on a write strobe aimed at it
        always_ff @(posedge clk) begin
            if (!rst_n)                          slot_q[i] <= '0;
            else if (wr_en && wr_ptr == SLOT_PTR) slot_q[i] <= wr_data;
        end
        assign ctrl_q[i*8 +: 8] = slot_q[i];
    end

    // Read multiplexer over control slots and the status slot
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < CTRL_COUNT; k++) begin
            if (rd_ptr == 8'(CTRL_BASE + k)) rd_data = slot_q[k];
        end
        if (rd_ptr == STATUS_PTR) rd_data = status_i;
    end
endmodule

// File: rtl/pinstrap_serial_regs.sv
// Top: two-wire serial slave with a pin-strapped address in front of two
// control registers and one read-only status byte.
// Assumes the open-drain data driver is outside: sda_oe=1 pulls the line low.
module pinstrap_serial_regs #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         CTRL_BASE   = 0,
    parameter logic [7:0] STATUS_PTR  = 8'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] strap_addr,
    input  logic [7:0] status_i,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b
);
    localparam int CTRL_COUNT = 2;

    logic                    sda_s;
    logic                    scl_rise;
    logic                    scl_fall;
    logic                    start_evt;
    logic                    stop_evt;
    logic [7:0]              rd_ptr;
    logic [7:0]              rd_data;
    logic                    wr_en;
    logic [7:0]              wr_ptr;
    logic [7:0]              wr_data;
    logic [CTRL_COUNT*8-1:0] ctrl_q;

    pssr_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    pssr_engine #(.DEV_TYPE(DEV_TYPE)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .strap_addr(strap_addr), .rd_data(rd_data), .rd_ptr(rd_ptr),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    pssr_regfile #(
        .CTRL_COUNT(CTRL_COUNT), .CTRL_BASE(CTRL_BASE), .STATUS_PTR(STATUS_PTR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_data(wr_data), .rd_ptr(rd_ptr), .status_i(status_i),
        .rd_data(rd_data), .ctrl_q(ctrl_q)
    );

    assign ctrl_a = ctrl_q[7:0];
    assign ctrl_b = ctrl_q[15:8];
endmodule

// File: rtl/pssr_checker.sv
// Checker: timing and update properties of the serial register slave,
// attached to the top through bind.
module pssr_checker #(
    parameter logic [7:0] A_PTR = 8'h00,
    parameter logic [7:0] B_PTR = 8'h01
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic [7:0] ctrl_a,
    input logic [7:0] ctrl_b,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       wr_en,
    input logic [7:0] wr_ptr,
    input logic [7:0] wr_data
);
    assert_reset_values_R11: assert property (@(posedge clk)
        !rst_n |=> (ctrl_a == 8'h00 && ctrl_b == 8'h00 && !sda_oe));

    assert_start_releases_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    assert_oe_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    assert_write_lands_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == A_PTR) |=> ctrl_a == $past(wr_data));

    assert_write_lands_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == B_PTR) |=> ctrl_b == $past(wr_data));

    assert_ctrl_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctrl_a) || !$stable(ctrl_b)) |-> $past(wr_en));
endmodule

bind pinstrap_serial_regs pssr_checker #(
    .A_PTR(8'(CTRL_BASE)), .B_PTR(8'(CTRL_BASE + 1))
) u_pssr_checker (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .start_evt(start_evt),
    .stop_evt(stop_evt), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data)
);

// File: tb/test_pinstrap_serial_regs.sv
// Bench: bit-banged bus master with a register model computed in the bench.
module test_pinstrap_serial_regs;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [2:0] strap = 3'd0;
    logic [7:0] status = 8'hA5;
    logic [7:0] ctrl_a, ctrl_b;
    int         checks = 0;
    int         errors = 0;
    int         r10_bad = 0;
    logic       done = 1'b0;
    logic       prev_oe = 1'b0;
    logic [7:0] exp_a = 8'h00, exp_b = 8'h00;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    pinstrap_serial_regs i_pinstrap_serial_regs (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_addr(strap), .status_i(status),
        .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
    );

    // R10 monitor: the enable may move only while the clock line is low
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl_m) r10_bad++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        sda_m = 1'b0; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl_m = 1'b1; hold(); sda_m = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hold(); scl_m = 1'b1; hold();
        ack = ~sda_line;
        scl_m = 1'b0; hold();
    endtask

    task automatic read_byte(output logic [7:0] b, input logic m_ack);
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            hold(); scl_m = 1'b1; hold();
            b = {b[6:0], sda_line};
            scl_m = 1'b0; hold();
        end
        sda_m = ~m_ack; hold(); scl_m = 1'b1; hold(); scl_m = 1'b0; hold();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] model_rd(input logic [7:0] p);
        if (p == 8'h00) return exp_a;
        if (p == 8'h01) return exp_b;
        if (p == 8'h0F) return status;
        return 8'h00;
    endfunction

    function automatic logic [7:0] dev(input logic [2:0] a, input logic rd);
        return {4'b0101, a, rd};
    endfunction

    // Complete write transfer: pointer then data bytes, each acknowledged
    task automatic wr_regs(input logic [7:0] p, input logic [7:0] d0,
                           input logic [7:0] d1, input int n, input string req);
        logic ack;
        bus_start();
        write_byte(dev(strap, 1'b0), ack); chk(req, {7'd0, ack}, 8'd1);
        write_byte(p, ack);                chk(req, {7'd0, ack}, 8'd1);
        write_byte(d0, ack);               chk(req, {7'd0, ack}, 8'd1);
        if (n > 1) begin
            write_byte(d1, ack);           chk(req, {7'd0, ack}, 8'd1);
        end
        bus_stop();
    endtask

    // Set the pointer, repeated start, then read n bytes, NACK on the last
    task automatic rd_burst(input logic [7:0] p, input int n, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        write_byte(dev(strap, 1'b0), ack); chk(req, {7'd0, ack}, 8'd1);
        write_byte(p, ack);                chk(req, {7'd0, ack}, 8'd1);
        bus_start();
        write_byte(dev(strap, 1'b1), ack); chk(req, {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            read_byte(b, i != n - 1);
            chk(req, b, model_rd(8'(p + i)));
        end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 ctrl_a", ctrl_a, 8'h00);
        chk("R11 ctrl_b", ctrl_b, 8'h00);
        chk("R11 sda_oe", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        hold();

        // R1: traffic with no start is ignored
        scl_m = 1'b0; hold();
        write_byte(dev(strap, 1'b0), ack);
        chk("R1 no ack before start", {7'd0, ack}, 8'd0);
        write_byte(8'h00, ack);
        write_byte(8'h3C, ack);
        chk("R1 no write before start", ctrl_a, exp_a);
        scl_m = 1'b1; hold();

        // R2/R3: full strap x address sweep, plus a foreign device type
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int a = 0; a < 8; a++) begin
                bus_start();
                write_byte(dev(3'(a), 1'b0), ack);
                chk(a == s ? "R2 match ack" : "R3 mismatch nack",
                    {7'd0, ack}, {7'd0, a == s});
                if (a != s) begin
                    write_byte(8'h00, ack);
                    chk("R3 silent until start", {7'd0, ack}, 8'd0);
                end
                bus_stop();
            end
        end
        strap = 3'd5;
        bus_start();
        write_byte({4'b0110, 3'd5, 1'b0}, ack);
        chk("R2 wrong device type", {7'd0, ack}, 8'd0);
        bus_stop();

        // R4: value sweep into both control registers
        for (int k = 0; k < 16; k++) begin
            logic [7:0] va, vb;
            va = 8'(k * 17 + 3);
            vb = ~8'(k * 29);
            wr_regs(8'h00, va, 8'h00, 1, "R4 write ack");
            exp_a = va;
            wr_regs(8'h01, vb, 8'h00, 1, "R4 write ack");
            exp_b = vb;
            chk("R4 ctrl_a", ctrl_a, exp_a);
            chk("R4 ctrl_b", ctrl_b, exp_b);
        end

        // R7: two data bytes land in consecutive registers
        wr_regs(8'h00, 8'h81, 8'h7E, 2, "R7 burst ack");
        exp_a = 8'h81; exp_b = 8'h7E;
        chk("R7 burst ctrl_a", ctrl_a, exp_a);
        chk("R7 burst ctrl_b", ctrl_b, exp_b);

        // R5: status slot and unmapped slots take writes without effect
        wr_regs(8'h0F, 8'h11, 8'h00, 1, "R5 status write ack");
        wr_regs(8'h05, 8'h22, 8'h00, 1, "R5 unmapped write ack");
        wr_regs(8'h01, 8'h66, 8'h44, 2, "R5 wrap past slot ack");
        exp_b = 8'h66;
        chk("R5 ctrl_a kept", ctrl_a, exp_a);
        chk("R5 ctrl_b", ctrl_b, exp_b);

        // R6/R7: read bursts across mapped, unmapped and status slots
        rd_burst(8'h00, 3, "R6 read from 00h");
        rd_burst(8'h0E, 3, "R6 read across 0Fh");
        status = 8'h3D;
        rd_burst(8'h0F, 1, "R6 status live value");
        rd_burst(8'h01, 2, "R7 read increments");

        // R8: after NACK the slave leaves the line alone
        bus_start();
        write_byte(dev(strap, 1'b0), ack);
        write_byte(8'h00, ack);
        bus_start();
        write_byte(dev(strap, 1'b1), ack);
        read_byte(b, 1'b0);
        chk("R8 byte before nack", b, exp_a);
        chk("R8 released", {7'd0, sda_oe}, 8'd0);
        read_byte(b, 1'b0);
        chk("R8 line stays high", b, 8'hFF);
        bus_stop();

        // R9: stop in mid data byte aborts without a write
        bus_start();
        write_byte(dev(strap, 1'b0), ack);
        write_byte(8'h00, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop();
        chk("R9 no partial write", ctrl_a, exp_a);
        scl_m = 1'b0; hold();
        write_byte(dev(strap, 1'b0), ack);
        chk("R9 idle after stop", {7'd0, ack}, 8'd0);
        scl_m = 1'b1; hold();
        wr_regs(8'h00, 8'h5A, 8'h00, 1, "R9 resume ack");
        exp_a = 8'h5A;
        chk("R9 write after stop", ctrl_a, exp_a);

        // R10: summary of the line-timing monitor
        chk("R10 oe moves only with scl low", 8'(r10_bad), 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule